// File: doc/BRIEF.md
# Strap-Selected Display Host Write Receiver

This block sits on the display-controller side of a host bus and turns host write cycles into a stream of tagged bytes. Two static strap inputs choose the bus personality. The choices are an Intel-style parallel bus with separate write and read strobes, a Motorola-style parallel bus with an enable pulse and a direction pin, a clocked serial link, and a two-wire mode. The two-wire mode is not handled here and is only flagged. Every host pin passes through a synchroniser into a fast internal clock. Edges on the host strobes are then found by sampling.

Each accepted byte leaves as a one-cycle `byte_valid` pulse with the byte value and a tag. The tag is taken from the host data/command pin: 1 means display data and 0 means command. Downstream command decoding consumes the stream the same way whichever bus is selected.

A mode state machine (`MS_BOOT`, `MS_I80`, `MS_M68`, `MS_SER`, `MS_UNSUP`) holds the selected personality. From `MS_BOOT` it moves to the state that the synchronised straps select. From any mode state it returns to `MS_BOOT` for one cycle whenever the straps no longer match, which clears both receivers.

The parallel receiver has two states, `PW_IDLE` and `PW_ACTIVE`:
- `PW_IDLE` goes to `PW_ACTIVE` when chip select is low and a write strobe is asserted.
- `PW_ACTIVE` goes back to `PW_IDLE` when the strobe ends, which emits a byte.
- It also goes back to `PW_IDLE`, with no byte, when chip select rises, when the direction pin turns to read, or when the block is disabled.

The serial receiver has two states, `SR_IDLE` and `SR_SHIFT`:
- `SR_IDLE` goes to `SR_SHIFT` while chip select is low.
- `SR_SHIFT` goes back to `SR_IDLE` when chip select rises or the mode changes. This drops any partial byte.

Top module: `hif_rx`

## Requirements
- R1: Straps (strap_a, strap_b) select the mode: (1,1) Intel-style parallel, (0,1) Motorola-style parallel, (0,0) serial, (1,0) two-wire. `mode_unsupported` is 1 only in two-wire mode.
- R2: In Intel-style mode, with host_cs_n low, a byte is emitted when host_wr (WR#, active low) rises. The byte is the host_d value present while host_wr was low. `byte_is_data` equals host_dc: 1 means data and 0 means command.
- R3: In Intel-style mode, a read cycle (host_rd low, host_wr high) emits no byte.
- R4: In Motorola-style mode, host_wr is the direction pin (1 is read, 0 is write) and host_rd is the enable pin. With host_cs_n low and host_wr low, a byte is emitted when host_rd falls, tagged from host_dc.
- R5: In Motorola-style mode, an enable pulse with host_wr high emits no byte.
- R6: A parallel strobe that ends after host_cs_n has already risen emits no byte.
- R7: In serial mode, host_d[0] is the shift clock and host_d[1] is the data. Bits enter MSB first. The byte completes on the eighth rising clock edge, and host_dc is sampled at that edge.
- R8: Raising host_cs_n part-way through a serial byte discards the bits received so far. The next byte starts again from bit 7.
- R9: In two-wire mode, no bus activity produces a byte.
- R10: While rst_n is low, byte_valid and byte_data are 0 and any partial serial byte is cleared.
- R11: byte_valid is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal fast clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_a | input | 1 | Mode strap, first bit |
| strap_b | input | 1 | Mode strap, second bit |
| host_cs_n | input | 1 | Host chip select, active low |
| host_dc | input | 1 | Host data/command select (1 = data) |
| host_wr | input | 1 | WR# in Intel-style mode, direction pin in Motorola-style mode |
| host_rd | input | 1 | RD# in Intel-style mode, enable pin in Motorola-style mode |
| host_d | input | DATA_W | Host data bus; bits 0 and 1 carry the serial clock and data |
| byte_valid | output | 1 | One-cycle pulse marking an accepted byte |
| byte_data | output | DATA_W | Accepted byte value |
| byte_is_data | output | 1 | Tag of the accepted byte (1 = data, 0 = command) |
| mode_unsupported | output | 1 | Straps select the two-wire mode |

## Verification
The hardest cases to reach are those where a serial byte is cut short: chip select rises, or reset pulses, after only some of the eight clock edges. The receiver must then start the next byte cleanly. The stimulus sends three or five serial bits, interrupts them, and then sends a full byte whose value would be corrupted by any leftover bits. A further serial byte changes host_dc just before the eighth edge to show that the tag is sampled there. A parallel write in which chip select rises before the write strobe ends tests the abort path of the parallel state machine.

// File: rtl/hif_rx_pkg.sv
package hif_rx_pkg;

    typedef enum logic [2:0] {
        MS_BOOT,
        MS_I80,
        MS_M68,
        MS_SER,
        MS_UNSUP
    } mode_state_e;

    typedef enum logic {
        PW_IDLE,
        PW_ACTIVE
    } par_state_e;

    typedef enum logic {
        SR_IDLE,
        SR_SHIFT
    } ser_state_e;

    function automatic mode_state_e decode_straps(input logic a, input logic b);
        mode_state_e m;
        unique case ({a, b})
            2'b11:   m = MS_I80;
            2'b01:   m = MS_M68;
            2'b00:   m = MS_SER;
            default: m = MS_UNSUP;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/hif_sync.sv
module hif_sync #(
    parameter int WIDTH = 8,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= RESET_VAL;
        else        pipe[0] <= d_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= RESET_VAL;
            else        pipe[s] <= pipe[s-1];
        end
    end

    assign d_out = pipe[STAGES-1];

endmodule

// File: rtl/hif_par_rx.sv
module hif_par_rx
    import hif_rx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          sel_m68,
    input  logic          cs_n,
    input  logic          dc,
    input  logic          wr,
    input  logic          rd,
    input  logic [DW-1:0] din,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_dc
);

    par_state_e state_q, state_d;
    logic [DW-1:0] hold_data;
    logic hold_dc;
    logic strobe_on, strobe_end, rw_abort, emit;

    // Intel-style: wr is WR#. Motorola-style: rd is enable, wr is direction.
    assign strobe_on  = sel_m68 ? (rd & ~wr) : ~wr;
    assign strobe_end = sel_m68 ? (~rd & ~wr) : wr;
    assign rw_abort   = sel_m68 & wr;
    assign emit = (state_q == PW_ACTIVE) && enable && !cs_n && strobe_end;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PW_IDLE: begin
                if (enable && !cs_n && strobe_on) state_d = PW_ACTIVE;
            end
            PW_ACTIVE: begin
                if (!enable || cs_n)  state_d = PW_IDLE;
                else if (strobe_end)  state_d = PW_IDLE;
                else if (rw_abort)    state_d = PW_IDLE;
            end
            default: state_d = PW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PW_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_data <= '0;
            hold_dc   <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_dc    <= 1'b0;
        end else begin
            if (enable && !cs_n && strobe_on) begin
                hold_data <= din;
                hold_dc   <= dc;
            end
            out_valid <= emit;
            if (emit) begin
                out_data <= hold_data;
                out_dc   <= hold_dc;
            end
        end
    end

    // R2
    par_emit_from_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(state_q) == PW_ACTIVE);

    // R6
    par_cs_high_no_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !out_valid);

endmodule

// File: rtl/hif_ser_rx.sv
module hif_ser_rx
    import hif_rx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          cs_n,
    input  logic          dc,
    input  logic          sclk,
    input  logic          sdin,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_dc
);

    localparam int CNT_W = $clog2(DW);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW - 1);

    ser_state_e state_q, state_d;
    logic [CNT_W-1:0] bit_cnt;
    logic [DW-1:0] shreg;
    logic sclk_q, sclk_rise, going_idle;

    assign sclk_rise  = sclk & ~sclk_q;
    assign going_idle = (state_d == SR_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SR_IDLE:  if (enable && !cs_n) state_d = SR_SHIFT;
            SR_SHIFT: if (!enable || cs_n) state_d = SR_IDLE;
            default:  state_d = SR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SR_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q    <= 1'b0;
            bit_cnt   <= '0;
            shreg     <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_dc    <= 1'b0;
        end else begin
            sclk_q    <= sclk;
            out_valid <= 1'b0;
            if (going_idle) begin
                bit_cnt <= '0;
                shreg   <= '0;
            end else if (state_q == SR_SHIFT && sclk_rise) begin
                if (bit_cnt == LAST_BIT) begin
                    out_valid <= 1'b1;
                    out_data  <= {shreg[DW-2:0], sdin};
                    out_dc    <= dc;
                    bit_cnt   <= '0;
                    shreg     <= '0;
                end else begin
                    shreg   <= {shreg[DW-2:0], sdin};
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // R8
    ser_idle_cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SR_IDLE) |-> (bit_cnt == '0));

    // R8
    ser_cs_high_no_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !out_valid);

    // R7
    ser_byte_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(sclk_rise));

endmodule

// File: rtl/hif_rx.sv
module hif_rx
    import hif_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_a,
    input  logic              strap_b,
    input  logic              host_cs_n,
    input  logic              host_dc,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_d,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_data,
    output logic              byte_is_data,
    output logic              mode_unsupported
);

    localparam int SYNC_W = DATA_W + 6;
    localparam logic [SYNC_W-1:0] SYNC_RST = {6'b111111, {DATA_W{1'b0}}};

    logic [SYNC_W-1:0] raw_bus, sync_bus;
    logic a_s, b_s, cs_s, dc_s, wr_s, rd_s;
    logic [DATA_W-1:0] d_s;

    assign raw_bus = {strap_a, strap_b, host_cs_n, host_dc, host_wr, host_rd, host_d};

    hif_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES), .RESET_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_bus),
        .d_out (sync_bus)
    );

    assign {a_s, b_s, cs_s, dc_s, wr_s, rd_s, d_s} = sync_bus;

    mode_state_e mode_q, mode_d, strap_mode;

    always_comb begin
        strap_mode = decode_straps(a_s, b_s);
        mode_d = mode_q;
        unique case (mode_q)
            MS_BOOT: mode_d = strap_mode;
            MS_I80, MS_M68, MS_SER, MS_UNSUP: begin
                if (strap_mode != mode_q) mode_d = MS_BOOT;
            end
            default: mode_d = MS_BOOT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MS_BOOT;
        else        mode_q <= mode_d;
    end

    logic par_en, ser_en, sel_m68;
    assign par_en  = (mode_q == MS_I80) || (mode_q == MS_M68);
    assign sel_m68 = (mode_q == MS_M68);
    assign ser_en  = (mode_q == MS_SER);

    logic par_v, par_dc, ser_v, ser_dc;
    logic [DATA_W-1:0] par_d, ser_d;

    hif_par_rx #(.DW(DATA_W)) u_par (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (par_en),
        .sel_m68   (sel_m68),
        .cs_n      (cs_s),
        .dc        (dc_s),
        .wr        (wr_s),
        .rd        (rd_s),
        .din       (d_s),
        .out_valid (par_v),
        .out_data  (par_d),
        .out_dc    (par_dc)
    );

    hif_ser_rx #(.DW(DATA_W)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (ser_en),
        .cs_n      (cs_s),
        .dc        (dc_s),
        .sclk      (d_s[0]),
        .sdin      (d_s[1]),
        .out_valid (ser_v),
        .out_data  (ser_d),
        .out_dc    (ser_dc)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_valid       <= 1'b0;
            byte_data        <= '0;
            byte_is_data     <= 1'b0;
            mode_unsupported <= 1'b0;
        end else begin
            mode_unsupported <= (mode_d == MS_UNSUP);
            byte_valid       <= par_v | ser_v;
            if (par_v) begin
                byte_data    <= par_d;
                byte_is_data <= par_dc;
            end else if (ser_v) begin
                byte_data    <= ser_d;
                byte_is_data <= ser_dc;
            end
        end
    end

    // R11
    byte_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    // R9
    unsup_no_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_unsupported |-> !byte_valid);

    // R1
    one_receiver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(par_v && ser_v));

    // R10
    always_ff @(posedge clk) begin
        if (!rst_n) reset_outputs_chk: assert (!byte_valid && byte_data == '0);
    end

endmodule

// File: tb/tb_hif_rx.sv
module tb_hif_rx;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strap_a = 1'b1, strap_b = 1'b1;
    logic host_cs_n = 1'b1, host_dc = 1'b1, host_wr = 1'b1, host_rd = 1'b1;
    logic [DW-1:0] host_d = '0;
    logic byte_valid, byte_is_data, mode_unsupported;
    logic [DW-1:0] byte_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    hif_rx #(.DATA_W(DW), .SYNC_STAGES(2)) dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .strap_a          (strap_a),
        .strap_b          (strap_b),
        .host_cs_n        (host_cs_n),
        .host_dc          (host_dc),
        .host_wr          (host_wr),
        .host_rd          (host_rd),
        .host_d           (host_d),
        .byte_valid       (byte_valid),
        .byte_data        (byte_data),
        .byte_is_data     (byte_is_data),
        .mode_unsupported (mode_unsupported)
    );

    int checks = 0, failures = 0;
    int got_cnt = 0, pulse_bad = 0;
    logic [DW-1:0] got_d = '0;
    logic got_dc = 1'b0, prev_v = 1'b0;
    bit finished = 0;

    always @(negedge clk) begin
        if (rst_n && byte_valid) begin
            got_cnt++;
            got_d  = byte_data;
            got_dc = byte_is_data;
            if (prev_v) pulse_bad++;
        end
        prev_v = byte_valid;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic a, input logic b);
        strap_a = a; strap_b = b;
        host_cs_n = 1'b1;
        host_wr = 1'b1;
        host_rd = (a & b) ? 1'b1 : 1'b0;   // RD# idle high, enable idle low
        host_d = '0;
        cyc(10);
    endtask

    task automatic i80_cycle(input logic rd_op, input logic dc, input logic [DW-1:0] v);
        host_cs_n = 1'b0; host_dc = dc; host_d = v; cyc(3);
        if (rd_op) host_rd = 1'b0; else host_wr = 1'b0;
        cyc(4);
        host_rd = 1'b1; host_wr = 1'b1; cyc(4);
        host_cs_n = 1'b1; cyc(6);
    endtask

    task automatic m68_cycle(input logic rd_op, input logic dc, input logic [DW-1:0] v);
        host_cs_n = 1'b0; host_dc = dc; host_d = v; host_wr = rd_op; cyc(3);
        host_rd = 1'b1; cyc(4);
        host_rd = 1'b0; cyc(4);
        host_cs_n = 1'b1; host_wr = 1'b1; cyc(6);
    endtask

    task automatic ser_bits(input logic [DW-1:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            host_d[0] = 1'b0; host_d[1] = v[DW-1-i]; cyc(3);
            host_d[0] = 1'b1; cyc(3);
        end
        host_d[0] = 1'b0; cyc(3);
    endtask

    task automatic ser_byte(input logic dc, input logic [DW-1:0] v);
        host_cs_n = 1'b0; host_dc = dc; cyc(3);
        ser_bits(v, DW);
        cyc(4); host_cs_n = 1'b1; cyc(6);
    endtask

    typedef struct packed {
        logic [1:0]    straps;
        logic          rd_op;
        logic          dc;
        logic [DW-1:0] val;
        logic          exp;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{2'b11, 1'b0, 1'b1, 8'hA5, 1'b1},
        '{2'b11, 1'b0, 1'b0, 8'h3C, 1'b1},
        '{2'b11, 1'b1, 1'b1, 8'hFF, 1'b0},
        '{2'b01, 1'b0, 1'b1, 8'h5A, 1'b1},
        '{2'b01, 1'b0, 1'b0, 8'h81, 1'b1},
        '{2'b01, 1'b1, 1'b1, 8'h77, 1'b0},
        '{2'b00, 1'b0, 1'b1, 8'hC3, 1'b1},
        '{2'b00, 1'b0, 1'b0, 8'h01, 1'b1},
        '{2'b10, 1'b0, 1'b1, 8'h99, 1'b0},
        '{2'b10, 1'b1, 1'b0, 8'h42, 1'b0},
        '{2'b11, 1'b0, 1'b1, 8'h00, 1'b1}
    };

    function automatic string tag_of(input vec_t v);
        if (v.straps == 2'b10) return "R9";
        if (v.straps == 2'b00) return "R7";
        if (v.straps == 2'b11) return v.rd_op ? "R3" : "R2";
        return v.rd_op ? "R5" : "R4";
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int base;
        cyc(3);
        chk("R10 reset valid", byte_valid, 0);
        chk("R10 reset data", byte_data, 0);
        rst_n = 1'b1;
        cyc(2);

        foreach (VECS[k]) begin
            set_mode(VECS[k].straps[1], VECS[k].straps[0]);
            chk("R1 unsupported flag", mode_unsupported, VECS[k].straps == 2'b10);
            base = got_cnt;
            unique case (VECS[k].straps)
                2'b11, 2'b10: i80_cycle(VECS[k].rd_op, VECS[k].dc, VECS[k].val);
                2'b01:        m68_cycle(VECS[k].rd_op, VECS[k].dc, VECS[k].val);
                default:      ser_byte(VECS[k].dc, VECS[k].val);
            endcase
            if (VECS[k].straps == 2'b10) ser_byte(VECS[k].dc, VECS[k].val);
            chk({tag_of(VECS[k]), " count"}, got_cnt - base, int'(VECS[k].exp));
            if (VECS[k].exp) begin
                chk({tag_of(VECS[k]), " data"}, got_d, VECS[k].val);
                chk({tag_of(VECS[k]), " tag"}, got_dc, VECS[k].dc);
            end
        end

        // R6: chip select released while the write strobe is still low
        set_mode(1'b1, 1'b1);
        base = got_cnt;
        host_cs_n = 1'b0; host_d = 8'h6E; cyc(3);
        host_wr = 1'b0; cyc(4);
        host_cs_n = 1'b1; cyc(4);
        host_wr = 1'b1; cyc(8);
        chk("R6 late strobe end", got_cnt - base, 0);

        // R7: tag sampled with the eighth bit
        set_mode(1'b0, 1'b0);
        base = got_cnt;
        host_cs_n = 1'b0; host_dc = 1'b0; cyc(3);
        ser_bits(8'hB4, 7);
        host_dc = 1'b1;
        host_d[1] = 1'b0; cyc(3);
        host_d[0] = 1'b1; cyc(3);
        host_d[0] = 1'b0; cyc(6);
        host_cs_n = 1'b1; cyc(6);
        chk("R7 late dc count", got_cnt - base, 1);
        chk("R7 late dc data", got_d, 8'hB4);
        chk("R7 late dc tag", got_dc, 1);

        // R8: partial byte dropped on chip-select release
        base = got_cnt;
        host_cs_n = 1'b0; cyc(3);
        ser_bits(8'hFF, 3);
        host_cs_n = 1'b1; cyc(6);
        chk("R8 no byte from partial", got_cnt - base, 0);
        ser_byte(1'b0, 8'h2E);
        chk("R8 count after abort", got_cnt - base, 1);
        chk("R8 data after abort", got_d, 8'h2E);

        // R10: reset in the middle of a serial byte
        base = got_cnt;
        host_cs_n = 1'b0; host_dc = 1'b1; cyc(3);
        ser_bits(8'hFF, 5);
        rst_n = 1'b0; cyc(3);
        chk("R10 valid during reset", byte_valid, 0);
        rst_n = 1'b1; cyc(10);
        ser_bits(8'h6B, 8);
        cyc(4); host_cs_n = 1'b1; cyc(6);
        chk("R10 count after reset", got_cnt - base, 1);
        chk("R10 data after reset", got_d, 8'h6B);

        chk("R11 single-cycle pulses", pulse_bad, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule